// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This block turns one 8-bit operand specifier into something an execution stage can use. A specifier names a short signed constant, a register, or a memory word reached through a register. For a source operand the block returns the operand's 16-bit value, and reads memory when the mode calls for it. For a destination operand it returns the write target: a register index, or a memory address. It never reads memory for a destination.

The block holds a 32-entry file of 16-bit registers. Another stage writes that file through a write port. The two auto-step modes, post-increment and post-decrement, update their base register inside the block and also report the update on a writeback output. Memory is word addressed, 16 bits wide, with a 16-bit address. Each read is one valid/ready handshake. Each operation ends with a one-cycle done pulse. The results stay on their outputs until the next operation ends.

Top module: `oamu_top`

## Requirements
- R1: With specifier bits 7:5 = 000, the source value is bits 4:0 read as a two's-complement number and sign-extended to 16 bits. No memory request is made. Done pulses in the cycle after the start cycle.
- R2: An immediate (bits 7:5 = 000) used as a destination sets `op_illegal` with done. It produces no writeback and changes no register.
- R3: With bits 7:5 = 001, a source returns register[bits 4:0]. A destination returns `tgt_reg` = bits 4:0 with `tgt_is_mem` = 0. Neither makes a memory request.
- R4: When bit 7 = 1, the address is register[bits 4:0] + bits 6:5, taken modulo 2^16, so pattern 100 is an offset of 0. A source reads that address and returns the read data. A destination returns it as `tgt_addr` with `tgt_is_mem` = 1 and makes no request.
- R5: For bits 7:5 = 010, the address is the register's old value. The register then becomes old+1, wrapping 0xFFFF to 0x0000. `wb_valid` pulses with done, carrying the index and the new value.
- R6: For bits 7:5 = 011, the address is the register's old value. The register then becomes old-1, wrapping 0x0000 to 0xFFFF. The writeback is reported as in R5.
- R7: A memory request holds `mem_valid` and a stable `mem_addr` until `mem_ready`. Done pulses in the cycle after the handshake, and `mem_valid` drops then.
- R8: `op_ready` is low while a memory read is outstanding. A start in that time is ignored. Done is never raised without an accepted start or a handshake.
- R9: If an auto-step update and an external register write hit the same index on the same edge, the auto-step value is stored.
- R10: After reset, done and `mem_valid` are low, `op_ready` is high, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Start resolving `op_spec` (taken when `op_ready`) |
| op_spec | input | 8 | Operand specifier |
| op_is_dst | input | 1 | 1 = destination operand, 0 = source |
| op_ready | output | 1 | Idle, able to accept a start |
| op_done | output | 1 | One-cycle pulse: result outputs are valid |
| op_value | output | 16 | Resolved source value |
| op_illegal | output | 1 | Immediate used as destination |
| tgt_is_mem | output | 1 | Destination is a memory word |
| tgt_addr | output | 16 | Destination memory address |
| tgt_reg | output | 5 | Destination register index |
| wb_valid | output | 1 | Auto-step register update happened |
| wb_idx | output | 5 | Index of the updated register |
| wb_data | output | 16 | New value of the updated register |
| mem_valid | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory word address |
| mem_ready | input | 1 | Memory accepts the request, `mem_rdata` valid |
| mem_rdata | input | 16 | Memory read data |
| rf_wr_en | input | 1 | External register write enable |
| rf_wr_idx | input | 5 | External register write index |
| rf_wr_data | input | 16 | External register write data |

## Verification
The assertions check the following on every cycle:
- the request stays stable while memory stalls;
- done follows a handshake;
- done never appears without an accepted start or a handshake;
- an immediate never raises a memory request;
- an illegal operand never comes with a writeback.

Other behaviours only the bench scenarios can show:
- the computed addresses and sign extension;
- the wrap of the step at both ends of the 16-bit range;
- the old-value-then-step order;
- the write priority on a collision;
- that a start while busy leaves the registers untouched.

The bench shows these by reading the registers back through register-direct operands.

// File: rtl/oamu_pkg.sv
package oamu_pkg;
  localparam int DW      = 16;
  localparam int NREG    = 32;
  localparam int IW      = $clog2(NREG);
  localparam int SPEC_W  = 8;
  localparam int OFF_W   = 2;

  typedef logic [DW-1:0] word_t;
  typedef logic [IW-1:0] ridx_t;

  typedef enum logic [2:0] {
    M_IMM  = 3'd0,
    M_REG  = 3'd1,
    M_PINC = 3'd2,
    M_PDEC = 3'd3,
    M_IND  = 3'd4
  } amode_e;

  function automatic word_t sext_imm(input logic [IW-1:0] v);
    return {{(DW-IW){v[IW-1]}}, v};
  endfunction

  function automatic word_t step_reg(input word_t v, input logic up);
    return up ? v + word_t'(1) : v - word_t'(1);
  endfunction

  function automatic word_t add_off(input word_t base, input logic [OFF_W-1:0] off);
    return base + word_t'(off);
  endfunction
endpackage

// File: rtl/oamu_decode.sv
module oamu_decode
  import oamu_pkg::*;
(
  input  logic [SPEC_W-1:0] spec,
  output amode_e            mode,
  output ridx_t             idx,
  output logic [OFF_W-1:0]  off,
  output word_t             imm_val
);
  always_comb begin
    idx     = spec[IW-1:0];
    imm_val = sext_imm(spec[IW-1:0]);
    off     = '0;
    if (spec[SPEC_W-1]) begin
      mode = M_IND;
      off  = spec[SPEC_W-2 -: OFF_W];
    end else begin
      unique case (spec[SPEC_W-2 -: 2])
        2'b00:   mode = M_IMM;
        2'b01:   mode = M_REG;
        2'b10:   mode = M_PINC;
        default: mode = M_PDEC;
      endcase
    end
  end
endmodule

// File: rtl/oamu_regfile.sv
module oamu_regfile
  import oamu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ridx_t rd_idx,
  output word_t rd_data,
  input  logic  a_we,
  input  ridx_t a_idx,
  input  word_t a_data,
  input  logic  b_we,
  input  ridx_t b_idx,
  input  word_t b_data
);
  word_t ent [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    word_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (a_we && a_idx == ridx_t'(g)) q <= a_data;  // auto-step wins
      else if (b_we && b_idx == ridx_t'(g)) q <= b_data;
    end
    assign ent[g] = q;
  end

  assign rd_data = ent[rd_idx];
endmodule

// File: rtl/oamu_ctrl.sv
module oamu_ctrl
  import oamu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic             op_is_dst,
  input  amode_e           mode,
  input  ridx_t            idx,
  input  logic [OFF_W-1:0] off,
  input  word_t            imm_val,
  input  word_t            base,
  input  logic             mem_ready,
  input  word_t            mem_rdata,
  output logic             op_ready,
  output logic             mem_valid,
  output word_t            mem_addr,
  output logic             se_we,
  output ridx_t            se_idx,
  output word_t            se_data,
  output logic             op_done,
  output word_t            op_value,
  output logic             op_illegal,
  output logic             tgt_is_mem,
  output word_t            tgt_addr,
  output ridx_t            tgt_reg,
  output logic             wb_valid,
  output ridx_t            wb_idx,
  output word_t            wb_data
);
  logic  in_mem;
  word_t cap_addr, cap_step;
  ridx_t cap_idx;
  logic  cap_auto;

  logic  is_ind, is_auto, accept, go_mem, fin_direct, fin_mem;
  word_t eff_addr, stepped;

  always_comb begin
    is_ind     = (mode == M_PINC) || (mode == M_PDEC) || (mode == M_IND);
    is_auto    = (mode == M_PINC) || (mode == M_PDEC);
    eff_addr   = add_off(base, off);
    stepped    = step_reg(base, mode == M_PINC);
    accept     = op_start && !in_mem;
    go_mem     = accept && is_ind && !op_is_dst;
    fin_direct = accept && !go_mem;
    fin_mem    = in_mem && mem_ready;
    se_we      = (fin_direct && is_auto) || (fin_mem && cap_auto);
    se_idx     = in_mem ? cap_idx  : idx;
    se_data    = in_mem ? cap_step : stepped;
    op_ready   = !in_mem;
    mem_valid  = in_mem;
    mem_addr   = cap_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_mem     <= 1'b0;
      cap_addr   <= '0;
      cap_step   <= '0;
      cap_idx    <= '0;
      cap_auto   <= 1'b0;
      op_done    <= 1'b0;
      op_value   <= '0;
      op_illegal <= 1'b0;
      tgt_is_mem <= 1'b0;
      tgt_addr   <= '0;
      tgt_reg    <= '0;
      wb_valid   <= 1'b0;
      wb_idx     <= '0;
      wb_data    <= '0;
    end else begin
      op_done  <= 1'b0;
      wb_valid <= 1'b0;
      if (go_mem) begin
        in_mem   <= 1'b1;
        cap_addr <= eff_addr;
        cap_step <= stepped;
        cap_idx  <= idx;
        cap_auto <= is_auto;
      end
      if (fin_direct) begin
        op_done    <= 1'b1;
        op_illegal <= (mode == M_IMM) && op_is_dst;
        op_value   <= (mode == M_IMM) ? imm_val : base;
        tgt_is_mem <= is_ind;
        tgt_addr   <= eff_addr;
        tgt_reg    <= idx;
        wb_valid   <= is_auto;
        wb_idx     <= idx;
        wb_data    <= stepped;
      end
      if (fin_mem) begin
        in_mem     <= 1'b0;
        op_done    <= 1'b1;
        op_illegal <= 1'b0;
        op_value   <= mem_rdata;
        tgt_is_mem <= 1'b0;
        wb_valid   <= cap_auto;
        wb_idx     <= cap_idx;
        wb_data    <= cap_step;
      end
    end
  end

  AST_IMM_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !in_mem && mode == M_IMM) |=> !mem_valid); // R1
  AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    op_illegal |-> !wb_valid); // R2
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr))); // R7
  AST_MEM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (op_done && !mem_valid)); // R7
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_mem && !op_start) |=> !op_done); // R8
endmodule

// File: rtl/oamu_top.sv
module oamu_top
  import oamu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [SPEC_W-1:0] op_spec,
  input  logic              op_is_dst,
  output logic              op_ready,
  output logic              op_done,
  output logic [DW-1:0]     op_value,
  output logic              op_illegal,
  output logic              tgt_is_mem,
  output logic [DW-1:0]     tgt_addr,
  output logic [IW-1:0]     tgt_reg,
  output logic              wb_valid,
  output logic [IW-1:0]     wb_idx,
  output logic [DW-1:0]     wb_data,
  output logic              mem_valid,
  output logic [DW-1:0]     mem_addr,
  input  logic              mem_ready,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              rf_wr_en,
  input  logic [IW-1:0]     rf_wr_idx,
  input  logic [DW-1:0]     rf_wr_data
);
  amode_e           mode;
  ridx_t            idx;
  logic [OFF_W-1:0] off;
  word_t            imm_val, base;
  logic             se_we;
  ridx_t            se_idx;
  word_t            se_data;

  oamu_decode u_dec (
    .spec(op_spec), .mode(mode), .idx(idx), .off(off), .imm_val(imm_val)
  );

  oamu_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_data(base),
    .a_we(se_we), .a_idx(se_idx), .a_data(se_data),
    .b_we(rf_wr_en), .b_idx(rf_wr_idx), .b_data(rf_wr_data)
  );

  oamu_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_dst(op_is_dst),
    .mode(mode), .idx(idx), .off(off), .imm_val(imm_val), .base(base),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .op_ready(op_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .se_we(se_we),
    .se_idx(se_idx), .se_data(se_data), .op_done(op_done),
    .op_value(op_value), .op_illegal(op_illegal), .tgt_is_mem(tgt_is_mem),
    .tgt_addr(tgt_addr), .tgt_reg(tgt_reg), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data)
  );
endmodule

// File: tb/oamu_top_tb_top.sv
module oamu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 1'b0;
  logic [7:0]  op_spec = '0;
  logic        op_is_dst = 1'b0;
  logic        op_ready, op_done, op_illegal, tgt_is_mem, wb_valid, mem_valid;
  logic [15:0] op_value, tgt_addr, wb_data, mem_addr, mem_rdata;
  logic [4:0]  tgt_reg, wb_idx;
  logic        mem_ready;
  logic        rf_wr_en = 1'b0;
  logic [4:0]  rf_wr_idx = '0;
  logic [15:0] rf_wr_data = '0;

  int checks = 0;
  int failures = 0;
  int lat = 0;
  int wcnt = 0;
  int hs_cnt = 0;
  logic [15:0] model [32];

  always #2.5 clk = ~clk;

  oamu_top dut_i (.*);

  function automatic logic [15:0] mem_fn(input logic [15:0] a);
    return (a * 16'd7) ^ 16'h5A3C;
  endfunction

  assign mem_ready = mem_valid && (wcnt >= lat);
  assign mem_rdata = mem_fn(mem_addr);

  always_ff @(posedge clk) begin
    if (mem_valid && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_valid && mem_ready) hs_cnt <= hs_cnt + 1;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one operation; returns the number of falling edges waited after the accept edge.
  task automatic run_op(input logic [7:0] spec, input logic dst, output int waited);
    @(negedge clk);
    op_start = 1'b1; op_spec = spec; op_is_dst = dst;
    @(posedge clk);
    @(negedge clk);
    op_start = 1'b0;
    waited = 0;
    while (!op_done && waited < 50) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic read_reg(input logic [4:0] r, output logic [15:0] v);
    int w;
    run_op({3'b001, r}, 1'b0, w);
    v = op_value;
  endtask

  typedef struct packed {
    logic [7:0] spec;
    logic       dst;
    logic [1:0] lat;
    logic       exp_ill;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'b000_01111, 1'b0, 2'd0, 1'b0},
    '{8'b000_10000, 1'b0, 2'd0, 1'b0},
    '{8'b000_00011, 1'b1, 2'd0, 1'b1},
    '{8'b001_00101, 1'b0, 2'd0, 1'b0},
    '{8'b001_01001, 1'b1, 2'd0, 1'b0},
    '{8'b010_11111, 1'b0, 2'd2, 1'b0},
    '{8'b011_00000, 1'b0, 2'd1, 1'b0},
    '{8'b100_00100, 1'b0, 2'd0, 1'b0},
    '{8'b111_00110, 1'b0, 2'd3, 1'b0},
    '{8'b101_00110, 1'b1, 2'd0, 1'b0},
    '{8'b110_01100, 1'b0, 2'd0, 1'b0},
    '{8'b010_00011, 1'b1, 2'd0, 1'b0},
    '{8'b011_00011, 1'b0, 2'd1, 1'b0},
    '{8'b001_11111, 1'b0, 2'd0, 1'b0},
    '{8'b001_00000, 1'b0, 2'd0, 1'b0}
  };

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int w;
    #1;
    // R10: reset state
    chk("R10 done", 16'(op_done), 16'h0);
    chk("R10 mem_valid", 16'(mem_valid), 16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R10 ready", 16'(op_ready), 16'h1);
    read_reg(5'd10, v);
    chk("R10 reg zero", v, 16'h0);

    // preload registers through the external write port
    for (int i = 0; i < 32; i++) begin
      model[i] = (i == 31) ? 16'hFFFF : (i == 0) ? 16'h0000 : 16'(i * 16'h0123 + 16'h0040);
      @(negedge clk);
      rf_wr_en = 1'b1; rf_wr_idx = 5'(i); rf_wr_data = model[i];
    end
    @(negedge clk);
    rf_wr_en = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic [7:0]  sp;
      logic [2:0]  md;
      logic [4:0]  r;
      logic [15:0] addr, expv, nv;
      logic        ind, autostep, up;
      int          hs0;
      string       tag;
      sp = VECS[k].spec;
      md = sp[7:5];
      r  = sp[4:0];
      lat = int'(VECS[k].lat);
      ind = sp[7] || md == 3'b010 || md == 3'b011;
      autostep = (md == 3'b010) || (md == 3'b011);
      up = (md == 3'b010);
      addr = model[r] + (sp[7] ? {14'd0, sp[6:5]} : 16'd0);
      tag = (md == 3'b000) ? (VECS[k].dst ? "R2" : "R1") :
            (md == 3'b001) ? "R3" : (md == 3'b010) ? "R5" :
            (md == 3'b011) ? "R6" : "R4";
      hs0 = hs_cnt;
      run_op(sp, VECS[k].dst, w);
      chk({tag, " done"}, 16'(op_done), 16'h1);
      chk({tag, " illegal"}, 16'(op_illegal), 16'(VECS[k].exp_ill));
      if (ind && !VECS[k].dst) begin
        chk("R7 latency", 16'(w), 16'(lat + 1));
        chk({tag, " mem value"}, op_value, mem_fn(addr));
        chk("R7 one handshake", 16'(hs_cnt - hs0), 16'd1);
      end else begin
        chk("R8 latency", 16'(w), 16'd0);
        chk({tag, " no mem"}, 16'(hs_cnt - hs0), 16'd0);
        if (!VECS[k].dst) begin
          expv = (md == 3'b000) ? {{11{r[4]}}, r} : model[r];
          chk({tag, " value"}, op_value, expv);
        end else if (md != 3'b000) begin
          chk({tag, " tgt_is_mem"}, 16'(tgt_is_mem), 16'(ind));
          if (ind) chk({tag, " tgt_addr"}, tgt_addr, addr);
          else chk({tag, " tgt_reg"}, 16'(tgt_reg), 16'(r));
        end
      end
      chk({tag, " wb_valid"}, 16'(wb_valid), 16'(autostep));
      if (autostep) begin
        nv = up ? model[r] + 16'd1 : model[r] - 16'd1;
        chk({tag, " wb_idx"}, 16'(wb_idx), 16'(r));
        chk({tag, " wb_data"}, wb_data, nv);
        model[r] = nv;
      end
      lat = 0;
    end

    // R5 / R6 wrap observed through register reads
    read_reg(5'd31, v);
    chk("R5 wrap to zero", v, 16'h0000);
    read_reg(5'd0, v);
    chk("R6 wrap to FFFF", v, 16'hFFFF);

    // R9: collision of the auto-step and the external write on r3
    @(negedge clk);
    op_start = 1'b1; op_spec = 8'b010_00011; op_is_dst = 1'b1;
    rf_wr_en = 1'b1; rf_wr_idx = 5'd3; rf_wr_data = 16'hBEEF;
    @(posedge clk);
    @(negedge clk);
    op_start = 1'b0; rf_wr_en = 1'b0;
    model[3] = model[3] + 16'd1;
    read_reg(5'd3, v);
    chk("R9 auto-step wins", v, model[3]);

    // R8: a start while a read is outstanding is ignored
    lat = 3;
    @(negedge clk);
    op_start = 1'b1; op_spec = 8'b100_00010; op_is_dst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    op_start = 1'b1; op_spec = 8'b010_00111; op_is_dst = 1'b1;
    chk("R8 ready low", 16'(op_ready), 16'h0);
    @(posedge clk);
    @(negedge clk);
    op_start = 1'b0;
    w = 0;
    while (!op_done && w < 50) begin
      @(negedge clk);
      w++;
    end
    chk("R8 busy value", op_value, mem_fn(model[2]));
    lat = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R8 no extra done", 16'(op_done), 16'h0);
    end
    read_reg(5'd7, v);
    chk("R8 r7 untouched", v, model[7]);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule